// File: doc/BRIEF.md
# Set/Clear Aliased Register Bank

This block is a small register file on an APB-style bus. It sits inside a 16 Kbyte address window and decodes word offsets from the window's lowest address. It holds two registers that software writes often: a control word and an interrupt enable mask. Each of these can be reached at three word addresses. One address turns bits on, one turns bits off, and one reads the value back. Software can therefore change single bits without a read-modify-write sequence.

The block also holds a plain read/write mode register, a plain read/write data register, and a read-only status register. The status register samples a status input that stands in for the events of the peripheral. An interrupt line is raised whenever a sampled status bit meets an enabled mask bit.

A three-state phase tracker follows the bus handshake. The states are IDLE, SETUP and ACCESS, with these transitions:
- IDLE→SETUP when select rises with enable low.
- SETUP→ACCESS when enable goes high with select held; a write commits on this edge.
- SETUP→SETUP while select stays high and enable stays low.
- SETUP→IDLE when select drops.
- ACCESS→SETUP for a back-to-back transfer (select high, enable low).
- ACCESS→IDLE otherwise.

Top module: `sc_reg_bank`

## Requirements
- R1: After reset, the control, enable, mode, data and status registers read as zero, and `irq_o` is low.
- R2: A write to byte offset 0x000 (control set) or 0x010 (enable set) forces to 1 every register bit whose write-data bit is 1. Bits whose write-data bit is 0 keep their value.
- R3: A write to byte offset 0x004 (control clear) or 0x014 (enable clear) forces to 0 every register bit whose write-data bit is 1. Bits whose write-data bit is 0 keep their value.
- R4: Offsets 0x008 (control) and 0x018 (enable) read the current register value. Writes to these offsets change nothing.
- R5: Reads of the set and clear offsets (0x000, 0x004, 0x010, 0x014) return zero.
- R6: Offset 0x020 (mode) and offset 0x024 (data) are plain read/write registers of full data width.
- R7: Offset 0x028 reads the status input as it was sampled on the previous clock edge. Writes to 0x028 are ignored.
- R8: `irq_o` is high exactly when some status bit and its enable bit are both 1. It reflects a status change one edge after `status_in` changes, and an enable write on the edge that commits it.
- R9: An offset in the window that is not listed above, or an address whose two low bits are not zero, reads as zero. A write to such an address changes no register.
- R10: `pready` is always high. A write commits only on the edge that moves the handshake from SETUP to ACCESS with `pwrite` high. A setup phase with no enable phase, or an access with `pwrite` low, changes no register.
- R11: The enable mask has STAT_W bits and takes the low STAT_W bits of `pwdata`. Higher write-data bits are ignored, and reads of the mask and of status are zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus enable (access phase) |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (14) | Byte offset within the window |
| pwdata | input | DATA_W (32) | Write data |
| prdata | output | DATA_W (32) | Read data, zero when not selected |
| pready | output | 1 | Always 1 |
| status_in | input | STAT_W (8) | Peripheral event bits |
| irq_o | output | 1 | Masked status interrupt |

## Verification
The bench builds the block with its default parameters: DATA_W=32, STAT_W=8 and ADDR_W=14. Because STAT_W is narrower than DATA_W, writes that carry ones only above bit 7 reach the enable mask, and the bench can check that those bits are dropped. With a 14-bit offset, the highest word of the window (0x3FFC) and misaligned addresses can be reached as undecoded cases. An eight-bit status vector is enough to show masked bits holding the interrupt low while an enabled bit raises it.

// File: rtl/sc_pkg.sv
package sc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACCESS = 2'd2
    } apb_phase_e;

    localparam int N_SEL     = 9;
    localparam int IX_C_SET  = 0;
    localparam int IX_C_CLR  = 1;
    localparam int IX_C_RD   = 2;
    localparam int IX_E_SET  = 3;
    localparam int IX_E_CLR  = 4;
    localparam int IX_E_RD   = 5;
    localparam int IX_MODE   = 6;
    localparam int IX_DATA   = 7;
    localparam int IX_STAT   = 8;

    // word offset (byte offset / 4) of each decoded location
    function automatic int word_of(int ix);
        case (ix)
            IX_C_SET: return 0;
            IX_C_CLR: return 1;
            IX_C_RD:  return 2;
            IX_E_SET: return 4;
            IX_E_CLR: return 5;
            IX_E_RD:  return 6;
            IX_MODE:  return 8;
            IX_DATA:  return 9;
            default:  return 10;
        endcase
    endfunction

endpackage

// File: rtl/sc_addr_dec.sv
module sc_addr_dec
    import sc_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic [ADDR_W-1:0] paddr,
    output logic [N_SEL-1:0]  sel_o
);
    localparam int WA = ADDR_W - 2;

    logic aligned;
    assign aligned = (paddr[1:0] == 2'b00);

    for (genvar i = 0; i < N_SEL; i++) begin : g_match
        assign sel_o[i] = aligned && (paddr[ADDR_W-1:2] == WA'(word_of(i)));
    end

    // R9: at most one location matches any address
    always_comb begin
        a_r9_sel_onehot: assert ($onehot0(sel_o) || $isunknown(paddr));
    end
endmodule

// File: rtl/sc_alias_reg.sv
module sc_alias_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_i,
    input  logic         clr_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= '0;
        end else if (set_i) begin
            q_o <= q_o | d_i;
        end else if (clr_i) begin
            q_o <= q_o & ~d_i;
        end
    end

    a_r2_set_forces_ones: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> ((q_o & $past(d_i)) == $past(d_i)));

    a_r2_set_keeps_zeros_data: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> ((q_o & ~$past(d_i)) == ($past(q_o) & ~$past(d_i))));

    a_r3_clear_forces_zeros: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> ((q_o & $past(d_i)) == '0));

    a_r4_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/sc_reg_bank.sv
module sc_reg_bank
    import sc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int STAT_W = 8,
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    input  logic [STAT_W-1:0] status_in,
    output logic              irq_o
);
    apb_phase_e st_q, st_d;
    logic [N_SEL-1:0]  sel;
    logic              wr_stb;
    logic [DATA_W-1:0] ctrl_q, mode_q, data_q;
    logic [STAT_W-1:0] ien_q, stat_q;

    // ---- phase tracker: state register ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PH_IDLE;
        else        st_q <= st_d;
    end

    // ---- phase tracker: next state ----
    always_comb begin
        st_d = PH_IDLE;
        unique case (st_q)
            PH_IDLE:   st_d = (psel && !penable) ? PH_SETUP : PH_IDLE;
            PH_SETUP:  st_d = !psel ? PH_IDLE : (penable ? PH_ACCESS : PH_SETUP);
            PH_ACCESS: st_d = (psel && !penable) ? PH_SETUP : PH_IDLE;
            default:   st_d = PH_IDLE;
        endcase
    end

    // ---- outputs of the tracker ----
    always_comb begin
        wr_stb = (st_q == PH_SETUP) && psel && penable && pwrite;
        pready = 1'b1;
    end

    sc_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .paddr (paddr),
        .sel_o (sel)
    );

    sc_alias_reg #(.W(DATA_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (wr_stb && sel[IX_C_SET]),
        .clr_i (wr_stb && sel[IX_C_CLR]),
        .d_i   (pwdata),
        .q_o   (ctrl_q)
    );

    sc_alias_reg #(.W(STAT_W)) u_ien (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (wr_stb && sel[IX_E_SET]),
        .clr_i (wr_stb && sel[IX_E_CLR]),
        .d_i   (pwdata[STAT_W-1:0]),
        .q_o   (ien_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            data_q <= '0;
            stat_q <= '0;
        end else begin
            stat_q <= status_in;
            if (wr_stb && sel[IX_MODE]) mode_q <= pwdata;
            if (wr_stb && sel[IX_DATA]) data_q <= pwdata;
        end
    end

    always_comb begin
        prdata = '0;
        if (psel) begin
            if (sel[IX_C_RD]) prdata = ctrl_q;
            if (sel[IX_E_RD]) prdata = DATA_W'(ien_q);
            if (sel[IX_MODE]) prdata = mode_q;
            if (sel[IX_DATA]) prdata = data_q;
            if (sel[IX_STAT]) prdata = DATA_W'(stat_q);
        end
    end

    assign irq_o = |(stat_q & ien_q);

    a_r5_alias_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sel[IX_C_SET] || sel[IX_C_CLR] || sel[IX_E_SET] || sel[IX_E_CLR]) |-> (prdata == '0));

    a_r9_undecoded_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0) |-> (prdata == '0));

    a_r10_mode_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && sel[IX_MODE]) |=> $stable(mode_q));

    a_r10_data_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && sel[IX_DATA]) |=> $stable(data_q));

    a_r11_ien_read_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && sel[IX_E_RD]) |-> (prdata[DATA_W-1:STAT_W] == '0));
endmodule

// File: tb/sc_reg_bank_tb.sv
module sc_reg_bank_tb_top;
    localparam int CLK_P = 10;
    localparam int NV    = 30;

    typedef struct packed {
        logic        rd;
        logic [13:0] a;
        logic [31:0] d;
        logic [31:0] e;
        logic [3:0]  r;
    } vec_t;

    // rd=1: read a and expect e; rd=0: write d to a. r = requirement number
    localparam vec_t VECS [NV] = '{
        '{1'b0, 14'h000, 32'h0000_00F0, 32'h0, 4'd2},   // R2 ctrl set
        '{1'b1, 14'h008, 32'h0,         32'h0000_00F0, 4'd2},
        '{1'b0, 14'h000, 32'h0000_0F00, 32'h0, 4'd2},
        '{1'b1, 14'h008, 32'h0,         32'h0000_0FF0, 4'd2},
        '{1'b0, 14'h004, 32'h0000_0030, 32'h0, 4'd3},   // R3 ctrl clear
        '{1'b1, 14'h008, 32'h0,         32'h0000_0FC0, 4'd3},
        '{1'b1, 14'h000, 32'h0,         32'h0,         4'd5},  // R5
        '{1'b1, 14'h004, 32'h0,         32'h0,         4'd5},
        '{1'b0, 14'h008, 32'hFFFF_FFFF, 32'h0, 4'd4},   // R4 read alias write
        '{1'b1, 14'h008, 32'h0,         32'h0000_0FC0, 4'd4},
        '{1'b0, 14'h020, 32'h1234_5678, 32'h0, 4'd6},   // R6
        '{1'b1, 14'h020, 32'h0,         32'h1234_5678, 4'd6},
        '{1'b0, 14'h024, 32'hA5A5_0001, 32'h0, 4'd6},
        '{1'b1, 14'h024, 32'h0,         32'hA5A5_0001, 4'd6},
        '{1'b0, 14'h03C, 32'hDEAD_BEEF, 32'h0, 4'd9},   // R9 hole
        '{1'b1, 14'h03C, 32'h0,         32'h0,         4'd9},
        '{1'b0, 14'h021, 32'hFFFF_FFFF, 32'h0, 4'd9},   // misaligned
        '{1'b1, 14'h021, 32'h0,         32'h0,         4'd9},
        '{1'b1, 14'h020, 32'h0,         32'h1234_5678, 4'd9},
        '{1'b0, 14'h3FFC, 32'hFFFF_FFFF, 32'h0, 4'd9},
        '{1'b1, 14'h3FFC, 32'h0,        32'h0,         4'd9},
        '{1'b1, 14'h008, 32'h0,         32'h0000_0FC0, 4'd9},
        '{1'b0, 14'h010, 32'h0000_0005, 32'h0, 4'd2},   // enable set
        '{1'b1, 14'h018, 32'h0,         32'h0000_0005, 4'd2},
        '{1'b0, 14'h014, 32'h0000_0004, 32'h0, 4'd3},   // enable clear
        '{1'b1, 14'h018, 32'h0,         32'h0000_0001, 4'd3},
        '{1'b0, 14'h010, 32'hFFFF_FF00, 32'h0, 4'd11},  // R11 upper bits dropped
        '{1'b1, 14'h018, 32'h0,         32'h0000_0001, 4'd11},
        '{1'b0, 14'h004, 32'h0000_0000, 32'h0, 4'd3},   // zero clear: no effect
        '{1'b1, 14'h008, 32'h0,         32'h0000_0FC0, 4'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [13:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic [7:0]  status_in = '0;
    logic        irq_o;
    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] rv;

    always #(CLK_P/2) clk = ~clk;

    sc_reg_bank dut_i (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .status_in(status_in), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [13:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [13:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1; #1 d = prdata;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    initial begin
        #(CLK_P * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset values
        check("R1 irq", {31'b0, irq_o}, 32'h0);
        apb_rd(14'h008, rv); check("R1 ctrl", rv, 32'h0);
        apb_rd(14'h018, rv); check("R1 ien", rv, 32'h0);
        apb_rd(14'h020, rv); check("R1 mode", rv, 32'h0);
        apb_rd(14'h024, rv); check("R1 data", rv, 32'h0);
        apb_rd(14'h028, rv); check("R1 status", rv, 32'h0);
        check("R10 pready", {31'b0, pready}, 32'h1);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].rd) begin
                apb_rd(VECS[i].a, rv);
                check($sformatf("R%0d vec%0d", VECS[i].r, i), rv, VECS[i].e);
            end else begin
                apb_wr(VECS[i].a, VECS[i].d);
            end
        end

        // R7 / R8: enable mask is now 0x01
        @(negedge clk); status_in = 8'h02;
        @(negedge clk); check("R8 masked bit keeps irq low", {31'b0, irq_o}, 32'h0);
        apb_rd(14'h028, rv); check("R7 status read", rv, 32'h02);
        @(negedge clk); status_in = 8'h03;
        @(negedge clk); check("R8 enabled bit raises irq", {31'b0, irq_o}, 32'h1);
        apb_wr(14'h028, 32'h0000_00FF);
        apb_rd(14'h028, rv); check("R7 status write ignored", rv, 32'h03);
        apb_wr(14'h014, 32'h0000_0001);
        check("R8 irq drops after enable clear", {31'b0, irq_o}, 32'h0);
        apb_wr(14'h010, 32'h0000_0002);
        check("R8 irq after enable set", {31'b0, irq_o}, 32'h1);
        @(negedge clk); status_in = 8'h00;
        @(negedge clk); check("R8 irq follows status drop", {31'b0, irq_o}, 32'h0);

        // R10: setup phase without access phase
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = 14'h020; pwdata = 32'hFFFF_0000;
        @(negedge clk); psel = 0; pwrite = 0;
        apb_rd(14'h020, rv); check("R10 setup-only no write", rv, 32'h1234_5678);
        // R10: access with pwrite low on set alias
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = 14'h000; pwdata = 32'hFFFF_FFFF;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0;
        apb_rd(14'h008, rv); check("R10 read access no write", rv, 32'h0000_0FC0);
        check("R10 pready idle", {31'b0, pready}, 32'h1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule